// File: doc/BRIEF.md
# Four-Tone Noncoherent Energy Demodulator

This block turns a stream of signed audio samples carrying four-tone frequency-shift keying into 2-bit symbols. It never estimates carrier phase. For every symbol window it correlates the incoming samples against an in-phase and a quadrature reference of each tone, squares both correlator results, adds them into a per-tone energy, and declares the tone with the most energy. The same winning energy is compared with a programmable threshold, giving a flag that tells downstream framing logic whether a data signal is present at all.

A symbol synchroniser upstream supplies a boundary strobe marking the first sample of a symbol window. After that strobe the block counts valid samples by itself. Once a window is complete it starts the next one, so later strobes are only needed to correct alignment. With default parameters the sample rate is 8 kHz and the symbol rate is 100 baud, so a window is N = 80 samples and four tones give 200 bit/s.

Top module: `fsk4_energy_demod`

## Requirements
- R1: After reset, sym_o, sym_valid_o and data_present_o are all 0.
- R2: Symbol code k (0 to 3) stands for the tone with TONE_BASE + k*TONE_STEP whole cycles per window. With the defaults these are 10, 12, 14 and 16 cycles in 80 samples (1000, 1200, 1400 and 1600 Hz at 8 kHz). A clean tone of index k decodes to sym_o = k.
- R3: sym_valid_o is high for exactly one cycle. That cycle directly follows the clock edge that captures the N-th valid sample of a window. No pulse occurs earlier in the window.
- R4: The decision does not depend on the starting phase of the received tone.
- R5: When several tones have equal largest energy, the lowest tone index wins. An all-zero window decodes to 0.
- R6: data_present_o is 1 only when the winning energy is strictly greater than thresh_i. sym_o and data_present_o keep their values until the next sym_valid_o pulse.
- R7: A boundary strobe clears all correlators and restarts the sample count. A valid sample in the same cycle as the strobe is the first sample of the new window.
- R8: Samples that arrive after reset and before the first boundary strobe are ignored and produce no decision.
- R9: After a window completes, the next N valid samples form the following window without any new strobe.
- R10: Cycles with sample_valid_i low neither advance the count nor change the correlators.
- R11: Full-scale input of either polarity, including a full-scale square wave, cannot overflow the correlators or energies. A full-scale square wave at tone k decodes to k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | SAMPLE_W | Two's complement audio sample |
| sample_valid_i | input | 1 | sample_i holds a new sample this cycle |
| sym_start_i | input | 1 | Symbol boundary strobe from the synchroniser |
| thresh_i | input | 2*ACC_W+1 | Energy threshold for data presence |
| sym_o | output | 2 | Decided tone index |
| sym_valid_o | output | 1 | One-cycle pulse on a new decision |
| data_present_o | output | 1 | Winning energy exceeded thresh_i |

## Verification
Every result appears in the cycle that follows the clock edge capturing the N-th valid sample. The count of N starts at the boundary strobe or at the end of the previous window, and idle cycles in between are not counted. The bench changes inputs on falling edges. It reads the outputs at the falling edge after the last sample of a window. There it checks the pulse, the symbol and the presence flag, and it uses a running pulse count to confirm that no pulse came earlier. To check R6 it reads the held outputs again several idle cycles later. For R8 and for partial windows it compares pulse counts taken before and after the stimulus.

// File: rtl/fsk4_pkg.sv
package fsk4_pkg;

    localparam int NUM_TONES = 4;
    localparam int SYM_W     = 2;

    // Integer sine approximation (parabolic half-waves) used to build the
    // per-tone reference tables at elaboration. quad adds a quarter period.
    function automatic int ref_value(input int n, input int cycles, input int nsamp,
                                     input int amp, input bit quad);
        int p;
        int h;
        int q;
        int mag;
        p = (n * cycles + (quad ? nsamp / 4 : 0)) % nsamp;
        h = nsamp / 2;
        if (p < h) begin
            q = p;
        end else begin
            q = p - h;
        end
        mag = (4 * amp * q * (h - q)) / (h * h);
        return (p < h) ? mag : -mag;
    endfunction

endpackage

// File: rtl/fsk4_ref_rom.sv
module fsk4_ref_rom #(
    parameter int N         = 80,
    parameter int REF_W     = 8,
    parameter int TONE_BASE = 10,
    parameter int TONE_STEP = 2,
    localparam int CNT_W    = $clog2(N),
    localparam int NT       = fsk4_pkg::NUM_TONES
) (
    input  logic [CNT_W-1:0]           idx_i,
    output logic [NT-1:0][REF_W-1:0]   ref_i_o,
    output logic [NT-1:0][REF_W-1:0]   ref_q_o
);
    localparam int REF_AMP = (1 << (REF_W - 1)) - 1;

    logic [REF_W-1:0] tab_i [NT][N];
    logic [REF_W-1:0] tab_q [NT][N];

    for (genvar k = 0; k < NT; k++) begin : g_tone
        for (genvar n = 0; n < N; n++) begin : g_pt
            assign tab_i[k][n] = REF_W'(fsk4_pkg::ref_value(n, TONE_BASE + k * TONE_STEP,
                                                           N, REF_AMP, 1'b1));
            assign tab_q[k][n] = REF_W'(fsk4_pkg::ref_value(n, TONE_BASE + k * TONE_STEP,
                                                           N, REF_AMP, 1'b0));
        end
        assign ref_i_o[k] = tab_i[k][idx_i];
        assign ref_q_o[k] = tab_q[k][idx_i];
    end

endmodule

// File: rtl/fsk4_corr_bank.sv
module fsk4_corr_bank #(
    parameter int SAMPLE_W = 10,
    parameter int REF_W    = 8,
    parameter int ACC_W    = 25,
    localparam int NT      = fsk4_pkg::NUM_TONES,
    localparam int PROD_W  = SAMPLE_W + REF_W
) (
    input  logic [NT-1:0][ACC_W-1:0]  acc_i_i,
    input  logic [NT-1:0][ACC_W-1:0]  acc_q_i,
    input  logic                      clear_i,
    input  logic                      add_i,
    input  logic [SAMPLE_W-1:0]       sample_i,
    input  logic [NT-1:0][REF_W-1:0]  ref_i_i,
    input  logic [NT-1:0][REF_W-1:0]  ref_q_i,
    output logic [NT-1:0][ACC_W-1:0]  acc_i_o,
    output logic [NT-1:0][ACC_W-1:0]  acc_q_o
);
    for (genvar k = 0; k < NT; k++) begin : g_mac
        logic signed [PROD_W-1:0] prod_i;
        logic signed [PROD_W-1:0] prod_q;
        logic signed [ACC_W-1:0]  base_i;
        logic signed [ACC_W-1:0]  base_q;

        always_comb begin
            prod_i = $signed(sample_i) * $signed(ref_i_i[k]);
            prod_q = $signed(sample_i) * $signed(ref_q_i[k]);
            base_i = clear_i ? '0 : $signed(acc_i_i[k]);
            base_q = clear_i ? '0 : $signed(acc_q_i[k]);
            if (add_i) begin
                acc_i_o[k] = base_i + ACC_W'(prod_i);
                acc_q_o[k] = base_q + ACC_W'(prod_q);
            end else begin
                acc_i_o[k] = base_i;
                acc_q_o[k] = base_q;
            end
        end
    end

endmodule

// File: rtl/fsk4_energy_pick.sv
module fsk4_energy_pick #(
    parameter int ACC_W    = 25,
    localparam int NT      = fsk4_pkg::NUM_TONES,
    localparam int SQ_W    = 2 * ACC_W,
    localparam int ENERGY_W = 2 * ACC_W + 1
) (
    input  logic [NT-1:0][ACC_W-1:0]   acc_i_i,
    input  logic [NT-1:0][ACC_W-1:0]   acc_q_i,
    input  logic [ENERGY_W-1:0]        thresh_i,
    output logic [fsk4_pkg::SYM_W-1:0] best_o,
    output logic                       present_o
);
    logic [NT-1:0][ENERGY_W-1:0] energy;

    for (genvar k = 0; k < NT; k++) begin : g_sq
        logic signed [SQ_W-1:0] sq_i;
        logic signed [SQ_W-1:0] sq_q;
        always_comb begin
            sq_i      = $signed(acc_i_i[k]) * $signed(acc_i_i[k]);
            sq_q      = $signed(acc_q_i[k]) * $signed(acc_q_i[k]);
            energy[k] = {1'b0, sq_i} + {1'b0, sq_q};
        end
    end

    always_comb begin
        best_o = '0;
        for (int k = 1; k < NT; k++) begin
            if (energy[k] > energy[best_o]) begin
                best_o = fsk4_pkg::SYM_W'(k);
            end
        end
        present_o = energy[best_o] > thresh_i;
    end

endmodule

// File: rtl/fsk4_energy_demod.sv
module fsk4_energy_demod #(
    parameter int SAMPLE_W     = 10,
    parameter int REF_W        = 8,
    parameter int SAMPLE_RATE  = 8000,
    parameter int SYMBOL_RATE  = 100,
    parameter int TONE_BASE    = 10,
    parameter int TONE_STEP    = 2,
    localparam int N           = SAMPLE_RATE / SYMBOL_RATE,
    localparam int CNT_W       = $clog2(N),
    localparam int ACC_W       = SAMPLE_W + REF_W + $clog2(N),
    localparam int ENERGY_W    = 2 * ACC_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SAMPLE_W-1:0]        sample_i,
    input  logic                       sample_valid_i,
    input  logic                       sym_start_i,
    input  logic [ENERGY_W-1:0]        thresh_i,
    output logic [1:0]                 sym_o,
    output logic                       sym_valid_o,
    output logic                       data_present_o
);
    localparam int NT = fsk4_pkg::NUM_TONES;

    typedef struct packed {
        logic [CNT_W-1:0]          cnt;
        logic                      armed;
        logic [NT-1:0][ACC_W-1:0]  acc_i;
        logic [NT-1:0][ACC_W-1:0]  acc_q;
        logic [1:0]                sym;
        logic                      valid;
        logic                      present;
    } state_t;

    state_t st_q;
    state_t st_d;

    logic [CNT_W-1:0]          cnt_base;
    logic                      take;
    logic [NT-1:0][REF_W-1:0]  ref_i;
    logic [NT-1:0][REF_W-1:0]  ref_q;
    logic [NT-1:0][ACC_W-1:0]  acc_i_nx;
    logic [NT-1:0][ACC_W-1:0]  acc_q_nx;
    logic [1:0]                best;
    logic                      present;

    assign cnt_base = sym_start_i ? '0 : st_q.cnt;
    assign take     = (st_q.armed | sym_start_i) & sample_valid_i;

    fsk4_ref_rom #(
        .N(N), .REF_W(REF_W), .TONE_BASE(TONE_BASE), .TONE_STEP(TONE_STEP)
    ) i_rom (
        .idx_i   (cnt_base),
        .ref_i_o (ref_i),
        .ref_q_o (ref_q)
    );

    fsk4_corr_bank #(
        .SAMPLE_W(SAMPLE_W), .REF_W(REF_W), .ACC_W(ACC_W)
    ) i_corr (
        .acc_i_i  (st_q.acc_i),
        .acc_q_i  (st_q.acc_q),
        .clear_i  (sym_start_i),
        .add_i    (take),
        .sample_i (sample_i),
        .ref_i_i  (ref_i),
        .ref_q_i  (ref_q),
        .acc_i_o  (acc_i_nx),
        .acc_q_o  (acc_q_nx)
    );

    fsk4_energy_pick #(
        .ACC_W(ACC_W)
    ) i_pick (
        .acc_i_i   (acc_i_nx),
        .acc_q_i   (acc_q_nx),
        .thresh_i  (thresh_i),
        .best_o    (best),
        .present_o (present)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (sym_start_i) begin
            st_d.armed = 1'b1;
        end
        st_d.acc_i = acc_i_nx;
        st_d.acc_q = acc_q_nx;
        st_d.cnt   = cnt_base;
        if (take) begin
            if (cnt_base == CNT_W'(N - 1)) begin
                st_d.valid   = 1'b1;
                st_d.sym     = best;
                st_d.present = present;
                st_d.acc_i   = '0;
                st_d.acc_q   = '0;
                st_d.cnt     = '0;
            end else begin
                st_d.cnt = cnt_base + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sym_o          = st_q.sym;
    assign sym_valid_o    = st_q.valid;
    assign data_present_o = st_q.present;

endmodule

// File: rtl/fsk4_demod_checker.sv
module fsk4_demod_checker #(
    parameter int N = 80,
    localparam int CW = $clog2(N + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_valid_i,
    input  logic       sym_start_i,
    input  logic [1:0] sym_o,
    input  logic       sym_valid_o,
    input  logic       data_present_o
);
    logic          seen_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (sym_start_i) begin
                seen_q <= 1'b1;
                cnt_q  <= sample_valid_i ? CW'(1) : '0;
            end else if (seen_q && sample_valid_i) begin
                cnt_q <= (cnt_q == CW'(N)) ? CW'(1) : cnt_q + 1'b1;
            end
        end
    end

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid_o |=> !sym_valid_o); // R3

    AST_VALID_AT_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid_o |-> cnt_q == CW'(N)); // R7

    AST_VALID_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid_o |-> $past(sample_valid_i)); // R10

    AST_IDLE_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !sym_valid_o); // R8

    AST_OUTPUTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid_o |-> ($stable(sym_o) && $stable(data_present_o))); // R6

endmodule

bind fsk4_energy_demod fsk4_demod_checker #(.N(N)) i_fsk4_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sample_valid_i (sample_valid_i),
    .sym_start_i    (sym_start_i),
    .sym_o          (sym_o),
    .sym_valid_o    (sym_valid_o),
    .data_present_o (data_present_o)
);

// File: tb/test_fsk4_energy_demod.sv
module test_fsk4_energy_demod;

    localparam int    NS     = 80;
    localparam int    EW     = 51;
    localparam real   PI     = 3.14159265358979;
    localparam int    TONES [4] = '{10, 12, 14, 16};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [9:0]    sample_i = '0;
    logic          sample_valid_i = 1'b0;
    logic          sym_start_i = 1'b0;
    logic [EW-1:0] thresh_i = '0;
    logic [1:0]    sym_o;
    logic          sym_valid_o;
    logic          data_present_o;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fsk4_energy_demod i_fsk4_energy_demod (
        .clk            (clk),
        .rst_n          (rst_n),
        .sample_i       (sample_i),
        .sample_valid_i (sample_valid_i),
        .sym_start_i    (sym_start_i),
        .thresh_i       (thresh_i),
        .sym_o          (sym_o),
        .sym_valid_o    (sym_valid_o),
        .data_present_o (data_present_o)
    );

    always @(negedge clk) begin
        if (sym_valid_o) pulses <= pulses + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [9:0] tone_val(input int cyc, input int n, input real amp,
                                            input real ph, input bit square);
        real s;
        int  v;
        s = $sin(2.0 * PI * cyc * n / NS + ph);
        if (square) begin
            v = (s >= 0.0) ? 511 : -512;
        end else begin
            v = $rtoi(amp * s + ((s >= 0.0) ? 0.5 : -0.5));
            if (v > 511) v = 511;
            if (v < -512) v = -512;
        end
        return 10'(v);
    endfunction

    task automatic send(input logic [9:0] s, input logic v, input logic st);
        @(negedge clk);
        sample_i       = s;
        sample_valid_i = v;
        sym_start_i    = st;
    endtask

    // Drives one window; checks the pulse and outputs right after the last sample.
    task automatic drive_symbol(input string req, input int tone, input real amp,
                                input real ph, input bit strobe, input bit gaps,
                                input bit square, input bit exp_present);
        int p0;
        p0 = pulses;
        for (int n = 0; n < NS; n++) begin
            send(tone_val(TONES[tone], n, amp, ph, square), 1'b1, strobe && n == 0);
            if (gaps && (n % 7 == 3)) send('0, 1'b0, 1'b0);
        end
        send('0, 1'b0, 1'b0);
        #1;
        check(sym_valid_o === 1'b1, req, "sym_valid after last sample", sym_valid_o, 1);
        check(pulses - p0 == 1, req, "single pulse in window", pulses - p0, 1);
        check(sym_o === 2'(tone), req, "decided symbol", sym_o, tone);
        check(data_present_o === exp_present, req, "data present", data_present_o, exp_present);
    endtask

    task automatic t_reset;
        #1;
        check(sym_o === 2'd0, "R1", "sym_o after reset", sym_o, 0);
        check(sym_valid_o === 1'b0, "R1", "sym_valid_o after reset", sym_valid_o, 0);
        check(data_present_o === 1'b0, "R1", "data_present_o after reset", data_present_o, 0);
    endtask

    task automatic t_unarmed; // R8
        int p0;
        p0 = pulses;
        for (int n = 0; n < 2 * NS + 5; n++) send(tone_val(TONES[2], n, 400.0, 0.0, 1'b0), 1'b1, 1'b0);
        send('0, 1'b0, 1'b0);
        send('0, 1'b0, 1'b0);
        #1;
        check(pulses == p0, "R8", "pulses before first strobe", pulses - p0, 0);
        check(sym_o === 2'd0 && data_present_o === 1'b0, "R8", "outputs untouched", sym_o, 0);
    endtask

    task automatic t_tones; // R2, R3
        for (int k = 0; k < 4; k++) drive_symbol("R2", k, 400.0, 0.3 * k, 1'b1, 1'b0, 1'b0, 1'b1);
        for (int k = 3; k >= 0; k--) drive_symbol("R3", k, 300.0, 0.0, 1'b1, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_phase; // R4
        real ph [4] = '{0.0, 1.1, 2.5, 4.0};
        for (int i = 0; i < 4; i++) drive_symbol("R4", 1, 400.0, ph[i], 1'b1, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) drive_symbol("R4", 2, 400.0, ph[i] + 0.7, 1'b1, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_tie; // R5, R6 strict compare
        thresh_i = '0;
        drive_symbol("R5", 0, 0.0, 0.0, 1'b1, 1'b0, 1'b0, 1'b0);
        thresh_i = EW'(64'd1_000_000_000_000);
    endtask

    task automatic t_threshold; // R6
        drive_symbol("R6", 3, 400.0, 0.9, 1'b1, 1'b0, 1'b0, 1'b1);
        drive_symbol("R6", 1, 60.0, 0.2, 1'b1, 1'b0, 1'b0, 1'b0);
        drive_symbol("R6", 2, 400.0, 1.7, 1'b1, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 6; i++) send('0, 1'b0, 1'b0);
        #1;
        check(sym_valid_o === 1'b0, "R6", "no pulse while idle", sym_valid_o, 0);
        check(sym_o === 2'd2, "R6", "symbol held", sym_o, 2);
        check(data_present_o === 1'b1, "R6", "presence held", data_present_o, 1);
    endtask

    task automatic t_restart; // R7
        int p0;
        p0 = pulses;
        send(tone_val(TONES[3], 0, 400.0, 0.0, 1'b0), 1'b1, 1'b1);
        for (int n = 1; n < 30; n++) send(tone_val(TONES[3], n, 400.0, 0.0, 1'b0), 1'b1, 1'b0);
        #1;
        check(pulses == p0, "R7", "no pulse from partial window", pulses - p0, 0);
        drive_symbol("R7", 1, 400.0, 0.5, 1'b1, 1'b0, 1'b0, 1'b1);
        send('0, 1'b0, 1'b1);
        drive_symbol("R7", 0, 400.0, 0.0, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_freerun; // R9
        drive_symbol("R9", 3, 400.0, 0.0, 1'b1, 1'b0, 1'b0, 1'b1);
        drive_symbol("R9", 0, 400.0, 2.0, 1'b0, 1'b0, 1'b0, 1'b1);
        drive_symbol("R9", 2, 400.0, 3.0, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_gaps; // R10
        drive_symbol("R10", 2, 400.0, 0.4, 1'b1, 1'b1, 1'b0, 1'b1);
        drive_symbol("R10", 1, 400.0, 1.4, 1'b0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_fullscale; // R11
        for (int k = 0; k < 4; k++) drive_symbol("R11", k, 511.0, 0.0, 1'b1, 1'b0, 1'b1, 1'b1);
        drive_symbol("R11", 3, 511.0, 0.0, 1'b1, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        thresh_i = EW'(64'd1_000_000_000_000);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_unarmed();
        t_tones();
        t_phase();
        t_tie();
        t_threshold();
        t_restart();
        t_freerun();
        t_gaps();
        t_fullscale();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule